// File: doc/BRIEF.md
# Buffered PWM Compare Timer

This block is one timer channel. It has a 16-bit up-counter, two compare registers (A and B) and an optional third (E). Each compare register has a shadow buffer: the A buffer feeds A, the B buffer feeds B, and the E buffer feeds E. Compare A sets the period, because a match on A clears the counter. Compare B sets the duty of the PWM pin. Software writes the next value into a shadow buffer at any time. The channel copies that value into the live compare register on an event, chosen per pair by a transfer-mode register. The event is either that pair's own compare match or the counter clear. This lets a duty or period change land on a clean boundary, whatever moment the write happened.

The PWM pin is driven by a three-state machine. IDLE holds the pin low while the channel is stopped or out of PWM mode. IDLE moves to HIGH on the first counter clear in PWM mode. HIGH moves to LOW on a compare match B. LOW moves back to HIGH on the next clear. A clear in HIGH keeps the machine in HIGH. Every state returns to IDLE when PWM mode or run is dropped. The block has single-cycle strobes for match A, match B, match E and counter clear. The parameter `HAS_E` selects the variant with or without the E pair.

Top module: `buffered_pwm_timer`

## Requirements
- R1: After reset, every register reads 0, `pwm_out` is 0 and all event strobes are 0, so every pair starts with match-timed transfers.
- R2: Register map on the 4-bit address: 0 control, 1 transfer mode, 2 counter, 3/4/5 compare A/B/E, 6/7/8 buffer A/B/E. Control bits are: bit0 run, bit1 PWM mode, bit2/3/4 buffer enable A/B/E. Transfer-mode bits are: bit0/1/2 select A/B/E, where 1 means clear timing. A write takes effect at the next clock edge. A read is combinational.
- R3: While run is 1, the counter increments each cycle. In the cycle where it equals compare A, `evt_clear` is 1 and the counter becomes 0 at the next edge, so the period is A+1 cycles.
- R4: In PWM mode, `pwm_out` is high for B+1 cycles (counter 0 to B) and low for the rest of the period. Outside PWM mode, or with run at 0, it is 0.
- R5: With a pair's select bit at 0 and its buffer enabled, the buffer is copied into the compare register on the edge of that pair's compare match. The new value is readable in the next cycle. A clear alone does not copy.
- R6: With a select bit at 1 in PWM mode, the copy happens on the counter-clear edge only. The pair's own match alone does not copy. When match and clear coincide, one copy is made.
- R7: The E pair exists only when `HAS_E` is 1, and follows R5 and R6 with select bit 2 and `evt_match_e`.
- R8: Outside PWM mode a set select bit has no effect: the copy follows the pair's own match and no copy occurs on clear.
- R9: With a pair's buffer enable at 0, a write to the compare register changes it directly and no copy from the buffer ever occurs.
- R10: Transfer-mode bits above bit 2 always read 0. With `HAS_E` at 0, transfer-mode bit 2, control bit 4 and the E compare and buffer registers read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| pwm_out | output | 1 | PWM pin |
| evt_match_a | output | 1 | Counter equals compare A |
| evt_match_b | output | 1 | Counter equals compare B |
| evt_match_e | output | 1 | Counter equals compare E |
| evt_clear | output | 1 | Counter clears at next edge |

## Verification
A scoreboard measures each high pulse on the PWM pin. In each transfer mode the duty buffer is written after match B inside a period. With match timing, the following period still shows the old width and the one after shows the new width. With clear timing, the new width appears in the very next period, which separates the two modes. The E pair is observed by reading it back around the clear and around its own match, from a preset counter value. This is done once each with clear timing in PWM mode, with match timing, and with clear timing outside PWM mode. Together these runs separate the three copy rules and the buffer-disabled direct-write path. Reserved transfer-mode bits are written with ones and read back on both variants.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_XMODE    = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT    = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_CMP_BASE = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_BUF_BASE = 4'd6;

    localparam int MAX_PAIRS = 3;

    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_HIGH = 2'd1,
        OUT_LOW  = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/pbt_counter.sv
module pbt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             clear_o
);

    logic [CNT_W-1:0] count_q;

    assign clear_o = run_i && (count_q == period_i);
    assign count_o = count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (wr_i) begin
            count_q <= wdata_i;
        end else if (clear_o) begin
            count_q <= '0;
        end else if (run_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    // R3
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_o && !wr_i) |=> (count_o == '0));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clear_o && !wr_i) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_i) |=> $stable(count_o));

endmodule

// File: rtl/pbt_buf_pair.sv
module pbt_buf_pair #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmp_i,
    input  logic             wr_buf_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             buf_en_i,
    input  logic             sel_clr_i,
    input  logic             pwm_en_i,
    input  logic             clear_i,
    output logic             match_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] buf_o
);

    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] buf_q;
    logic             use_clear;
    logic             copy_now;

    assign match_o = run_i && (count_i == cmp_q);

    always_comb begin
        use_clear = sel_clr_i && pwm_en_i;
        copy_now  = buf_en_i && (use_clear ? clear_i : match_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            buf_q <= '0;
        end else begin
            if (wr_cmp_i) begin
                cmp_q <= wdata_i;
            end else if (copy_now) begin
                cmp_q <= buf_q;
            end
            if (wr_buf_i) begin
                buf_q <= wdata_i;
            end
        end
    end

    assign cmp_o = cmp_q;
    assign buf_o = buf_q;

    // R9
    no_copy_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en_i && !wr_cmp_i) |=> $stable(cmp_o));

    // R8
    sel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en_i && !match_o && !wr_cmp_i) |=> $stable(cmp_o));

    // R6
    clear_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en_i && sel_clr_i && pwm_en_i && clear_i && !wr_cmp_i) |=> (cmp_o == $past(buf_o)));

    // R6
    clear_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_clr_i && pwm_en_i && !clear_i && !wr_cmp_i) |=> $stable(cmp_o));

endmodule

// File: rtl/pbt_pwm_fsm.sv
module pbt_pwm_fsm
    import pbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_en_i,
    input  logic clear_i,
    input  logic match_b_i,
    output logic pwm_o
);

    pwm_state_e state_q;
    pwm_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!pwm_en_i) begin
            state_d = OUT_IDLE;
        end else begin
            unique case (state_q)
                OUT_IDLE: if (clear_i) state_d = OUT_HIGH;
                OUT_HIGH: begin
                    if (clear_i)        state_d = OUT_HIGH;
                    else if (match_b_i) state_d = OUT_LOW;
                end
                OUT_LOW:  if (clear_i) state_d = OUT_HIGH;
                default:  state_d = OUT_IDLE;
            endcase
        end
    end

    always_comb begin
        pwm_o = (state_q == OUT_HIGH);
    end

    // R4
    high_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en_i && clear_i) |=> pwm_o);

    // R4
    low_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en_i && match_b_i && !clear_i && state_q != OUT_IDLE) |=> !pwm_o);

    // R4
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en_i |=> !pwm_o);

endmodule

// File: rtl/buffered_pwm_timer.sv
module buffered_pwm_timer
    import pbt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter bit HAS_E = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              pwm_out,
    output logic              evt_match_a,
    output logic              evt_match_b,
    output logic              evt_match_e,
    output logic              evt_clear
);

    localparam int         NPAIR      = HAS_E ? 3 : 2;
    localparam logic [2:0] XSEL_MASK  = HAS_E ? 3'b111 : 3'b011;
    localparam logic [4:0] CTRL_MASK  = HAS_E ? 5'h1F : 5'h0F;
    localparam logic [CNT_W-1:0] XMODE_RD_MASK = CNT_W'(XSEL_MASK);

    logic [4:0]       ctrl_q;
    logic [2:0]       xsel_q;
    logic             run;
    logic             pwm_mode;
    logic [2:0]       buf_en;
    logic [CNT_W-1:0] count;
    logic             clr;
    logic [CNT_W-1:0] cmp_w [MAX_PAIRS];
    logic [CNT_W-1:0] buf_w [MAX_PAIRS];
    logic [MAX_PAIRS-1:0] match_w;
    logic             wr_count;

    assign run      = ctrl_q[0];
    assign pwm_mode = ctrl_q[1];
    assign buf_en   = ctrl_q[4:2];
    assign wr_count = bus_we && (bus_addr == ADDR_COUNT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            xsel_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_CTRL)  ctrl_q <= bus_wdata[4:0] & CTRL_MASK;
            if (bus_addr == ADDR_XMODE) xsel_q <= bus_wdata[2:0] & XSEL_MASK;
        end
    end

    pbt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .wr_i     (wr_count),
        .wdata_i  (bus_wdata),
        .period_i (cmp_w[0]),
        .count_o  (count),
        .clear_o  (clr)
    );

    for (genvar g = 0; g < MAX_PAIRS; g++) begin : g_pair
        if (g < NPAIR) begin : g_live
            pbt_buf_pair #(.CNT_W(CNT_W)) u_pair (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_cmp_i  (bus_we && (bus_addr == ADDR_CMP_BASE + 4'(g))),
                .wr_buf_i  (bus_we && (bus_addr == ADDR_BUF_BASE + 4'(g))),
                .wdata_i   (bus_wdata),
                .run_i     (run),
                .count_i   (count),
                .buf_en_i  (buf_en[g]),
                .sel_clr_i (xsel_q[g]),
                .pwm_en_i  (pwm_mode),
                .clear_i   (clr),
                .match_o   (match_w[g]),
                .cmp_o     (cmp_w[g]),
                .buf_o     (buf_w[g])
            );
        end else begin : g_absent
            assign match_w[g] = 1'b0;
            assign cmp_w[g]   = '0;
            assign buf_w[g]   = '0;
        end
    end

    pbt_pwm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_en_i  (pwm_mode && run),
        .clear_i   (clr),
        .match_b_i (match_w[1]),
        .pwm_o     (pwm_out)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL:          bus_rdata[4:0] = ctrl_q;
            ADDR_XMODE:         bus_rdata[2:0] = xsel_q;
            ADDR_COUNT:         bus_rdata = count;
            ADDR_CMP_BASE:      bus_rdata = cmp_w[0];
            ADDR_CMP_BASE + 1:  bus_rdata = cmp_w[1];
            ADDR_CMP_BASE + 2:  bus_rdata = cmp_w[2];
            ADDR_BUF_BASE:      bus_rdata = buf_w[0];
            ADDR_BUF_BASE + 1:  bus_rdata = buf_w[1];
            ADDR_BUF_BASE + 2:  bus_rdata = buf_w[2];
            default:            bus_rdata = '0;
        endcase
    end

    assign evt_match_a = match_w[0];
    assign evt_match_b = match_w[1];
    assign evt_match_e = match_w[2];
    assign evt_clear   = clr;

    // R10
    xmode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_XMODE) |-> ((bus_rdata & ~XMODE_RD_MASK) == '0));

    // R7
    no_e_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_E) |-> !evt_match_e);

endmodule

// File: tb/sim_buffered_pwm_timer.sv
`timescale 1ns/1ps
module sim_buffered_pwm_timer;

    localparam logic [3:0] A_CTRL = 4'd0, A_XMODE = 4'd1, A_COUNT = 4'd2;
    localparam logic [3:0] A_CMPA = 4'd3, A_CMPB = 4'd4, A_CMPE = 4'd5;
    localparam logic [3:0] A_BUFB = 4'd7, A_BUFE = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pwm_out, m_a, m_b, m_e, clr;

    logic        we1 = 1'b0;
    logic [3:0]  addr1 = '0;
    logic [15:0] wdata1 = '0;
    logic [15:0] rdata1;
    logic        pwm1, m_a1, m_b1, m_e1, clr1;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    bit mon_on = 1'b0;
    int hcnt = 0;

    always #4 clk = ~clk;

    buffered_pwm_timer #(.CNT_W(16), .HAS_E(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .pwm_out(pwm_out), .evt_match_a(m_a), .evt_match_b(m_b),
        .evt_match_e(m_e), .evt_clear(clr)
    );

    buffered_pwm_timer #(.CNT_W(16), .HAS_E(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_we(we1), .bus_addr(addr1), .bus_wdata(wdata1),
        .bus_rdata(rdata1), .pwm_out(pwm1), .evt_match_a(m_a1), .evt_match_b(m_b1),
        .evt_match_e(m_e1), .evt_clear(clr1)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wr1(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        we1 = 1'b1; addr1 = a; wdata1 = d;
        @(negedge clk);
        we1 = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    task automatic rd1(input logic [3:0] a, output int d);
        addr1 = a;
        #1;
        d = int'(rdata1);
    endtask

    task automatic wait_count(input int v);
        int c;
        bit hit = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            rd(A_COUNT, c);
            if (c == v) begin
                hit = 1'b1;
                break;
            end
        end
        if (!hit) check("wait_count timeout", 0, 1);
    endtask

    task automatic wait_pwm_high();
        bit hit = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (pwm_out) begin
                hit = 1'b1;
                break;
            end
        end
        if (!hit) check("R4 pwm never high", 0, 1);
    endtask

    task automatic drain_queue();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0) break;
        end
        if (exp_q.size() != 0) check("scoreboard drain", exp_q.size(), 0);
        mon_on = 1'b0;
    endtask

    // monitor: measures each high pulse and compares with the queued width
    always @(negedge clk) begin
        if (!mon_on) begin
            hcnt = 0;
        end else if (pwm_out) begin
            hcnt++;
        end else if (hcnt > 0) begin
            if (exp_q.size() > 0) check("R5/R6 pulse width", hcnt, exp_q.pop_front());
            hcnt = 0;
        end
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_XMODE, v); check("R1 xmode", v, 0);
        rd(A_COUNT, v); check("R1 count", v, 0);
        rd(A_CMPB, v);  check("R1 cmp_b", v, 0);
        check("R1 pwm_out", int'(pwm_out), 0);

        // R10 reserved transfer-mode bits
        wr(A_XMODE, 16'h00FF);
        rd(A_XMODE, v); check("R10 xmode reserved", v, 7);
        wr1(A_XMODE, 16'h00FF);
        rd1(A_XMODE, v); check("R10 xmode bit2 no-E", v, 3);
        wr1(A_BUFE, 16'd5);
        rd1(A_BUFE, v); check("R7 no-E buffer reads 0", v, 0);
        wr1(A_CTRL, 16'h00FF);
        rd1(A_CTRL, v); check("R10 ctrl bit4 no-E", v, 15);

        // R2/R4/R5 duty with match timing
        wr(A_CMPA, 16'd19);
        wr(A_CMPB, 16'd4);
        wr(A_BUFB, 16'd4);
        wr(A_XMODE, 16'd0);
        rd(A_CMPA, v); check("R2 cmp_a readback", v, 19);
        wr(A_CTRL, 16'd11);
        wait_pwm_high();
        wait_count(10);
        wr(A_BUFB, 16'd9);
        exp_q.push_back(5); exp_q.push_back(10); exp_q.push_back(10);
        mon_on = 1'b1;
        drain_queue();

        // R6 duty with clear timing
        wr(A_XMODE, 16'd2);
        wait_pwm_high();
        wait_count(10);
        wr(A_BUFB, 16'd2);
        exp_q.push_back(3); exp_q.push_back(3);
        mon_on = 1'b1;
        drain_queue();

        // R6/R7 E pair with clear timing in PWM mode
        wr(A_CTRL, 16'd0);
        wr(A_CMPE, 16'd3);
        wr(A_BUFE, 16'd7);
        wr(A_COUNT, 16'd10);
        wr(A_XMODE, 16'd6);
        wr(A_CTRL, 16'd19);
        wait_count(15);
        rd(A_CMPE, v); check("R6 E before clear", v, 3);
        wait_count(19);
        check("R3 evt_clear at A", int'(clr), 1);
        rd(A_CMPE, v); check("R6 E at clear cycle", v, 3);
        @(negedge clk);
        rd(A_COUNT, v); check("R3 wrap to 0", v, 0);
        rd(A_CMPE, v); check("R6 E after clear", v, 7);

        // R5/R7 E pair with match timing
        wr(A_CTRL, 16'd0);
        wr(A_CMPE, 16'd3);
        wr(A_COUNT, 16'd10);
        wr(A_XMODE, 16'd0);
        wr(A_CTRL, 16'd19);
        wait_count(1);
        rd(A_CMPE, v); check("R5 E unchanged by clear", v, 3);
        wait_count(3);
        check("R7 evt_match_e", int'(m_e), 1);
        @(negedge clk);
        rd(A_CMPE, v); check("R5 E after match", v, 7);

        // R8 select ignored outside PWM mode
        wr(A_CTRL, 16'd0);
        wr(A_CMPE, 16'd3);
        wr(A_COUNT, 16'd10);
        wr(A_XMODE, 16'd4);
        wr(A_CTRL, 16'd17);
        wait_count(1);
        rd(A_CMPE, v); check("R8 no copy on clear", v, 3);
        check("R4 pwm low outside PWM", int'(pwm_out), 0);
        wait_count(4);
        rd(A_CMPE, v); check("R8 copy on match", v, 7);

        // R9 buffer disabled
        wr(A_CTRL, 16'd0);
        wr(A_XMODE, 16'd0);
        wr(A_BUFE, 16'd12);
        wr(A_CMPE, 16'd5);
        rd(A_CMPE, v); check("R9 direct write", v, 5);
        wr(A_COUNT, 16'd10);
        wr(A_CTRL, 16'd3);
        wait_count(0);
        wait_count(7);
        rd(A_CMPE, v); check("R9 no copy", v, 5);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule